// File: doc/BRIEF.md
# Stochastic OR-Accumulate Dot-Product Unit

The unit forms an approximate dot product of a set of signed 8-bit activation/weight pairs. It converts the operands to unsigned magnitudes and turns each pair into a product bitstream by testing pseudo-random sample coordinates against both magnitudes. It merges every lane's bitstream through one OR gate and counts the ones over a fixed evaluation window of 256 cycles. There is no adder tree.

A single maximal-length LFSR supplies all the randomness. In each cycle its upper bits name the only lane that may fire. Its lower bits give two sample coordinates, one for the activation and one for the weight. Because at most one lane can produce a 1 in any cycle, the OR gate never loses a collision. The expected count is therefore proportional to the sum of magnitude products, and it holds up when most inputs are small. Signed operands are shifted by a fixed offset so the datapath stays unsigned. The cross terms that this offset introduces are removed downstream.

A caller drives the operands and raises `start` while the unit is idle. The operands are captured on that edge. After exactly 256 evaluation cycles the unit raises `done` for one cycle and then holds the count until the next accepted start.

Top module: `sc_or_mac`

## Requirements
- R1: After reset, `busy`, `done` and `count` are all zero.
- R2: A `start` sampled while idle captures `actIn` and `wgtIn`, clears `count`, seeds the LFSR, and raises `busy` on that same edge. Later changes to the operand inputs have no effect on the run.
- R3: `done` is high for exactly one cycle. It rises on the 256th clock edge after the edge that accepted `start`, and `busy` falls on that same edge.
- R4: `count` rises by at most one per cycle and never exceeds 256.
- R5: In any cycle at most one lane may produce a 1. The firing lane is the one whose index equals the top log2(LANES) bits of the LFSR. Bits [15:8] of the LFSR are the activation sample and bits [7:0] are the weight sample.
- R6: Each signed two's-complement operand becomes an unsigned magnitude by adding 128, which inverts bit 7. A lane fires only when the activation sample is below its activation magnitude and the weight sample is below its weight magnitude. If every activation is -128, the count is exactly 0.
- R7: The final count lies within 24 of sum(ua·uw)/(LANES·65536)·256, where ua and uw are the offset magnitudes.
- R8: For a given seed, the same operands always give a bit-identical count.
- R9: A `start` raised while busy is ignored. The count and the timing of `done` are the same as in a run with no such start.
- R10: Once `done` has fired, `count` holds its value until the next accepted start, whatever the operand inputs do.
- R11: A `start` raised in the cycle where `done` is high is accepted and begins a new run.
- R12: When only one lane has a non-minimal operand (sparse input), the count still follows R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new evaluation (honoured only when idle) |
| actIn | input | LANES*8 | Signed activations, lane i at bits [8i+7:8i] |
| wgtIn | input | LANES*8 | Signed weights, lane i at bits [8i+7:8i] |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse when the count is final |
| count | output | 16 | Number of cycles in which the OR output was 1 |

## Verification
Two functions can fall in the same cycle here: a run's completion pulse and the acceptance of a fresh start. The bench raises `start` with new operands in exactly the cycle that `done` is seen high. It reads the finished count in that same cycle. It then requires `busy` on the next edge, a second `done` 256 cycles later, and a count bit-identical to an earlier reference run with those operands. A second overlap is also tested: a start arriving mid-run is judged by comparing the count and the `done` timing against an undisturbed reference.

// File: rtl/sc_mac_pkg.sv
package sc_mac_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } macCtrl_t;

  function automatic logic [31:0] lfsrMask(input int width);
    logic [31:0] m;
    m = '0;
    case (width)
      18: begin m[17] = 1'b1; m[10] = 1'b1; end
      19: begin m[18] = 1'b1; m[5] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
      21: begin m[20] = 1'b1; m[18] = 1'b1; end
      22: begin m[21] = 1'b1; m[20] = 1'b1; end
      23: begin m[22] = 1'b1; m[17] = 1'b1; end
      24: begin m[23] = 1'b1; m[22] = 1'b1; m[21] = 1'b1; m[16] = 1'b1; end
      default: begin m[19] = 1'b1; m[16] = 1'b1; end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sc_mac_ctrl.sv
module sc_mac_ctrl
  import sc_mac_pkg::*;
#(
  parameter int STREAM_LEN = 256
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output macCtrl_t ctrl,
  output logic     busy,
  output logic     done
);
  localparam int CYC_W = $clog2(STREAM_LEN);
  localparam logic [CYC_W-1:0] LAST = CYC_W'(STREAM_LEN - 1);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t     state;
  logic [CYC_W-1:0] cycCnt;
  logic       lastCyc;

  assign lastCyc   = (cycCnt == LAST);
  assign ctrl.load = (state == ST_IDLE) && start;
  assign ctrl.step = (state == ST_RUN);
  assign busy      = (state == ST_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cycCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_RUN;
            cycCnt <= '0;
          end
        end
        ST_RUN: begin
          cycCnt <= cycCnt + 1'b1;
          if (lastCyc) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: completion is a single-cycle pulse
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: busy falls exactly when done rises
  a_r3_busy_drop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !busy);

  // R9: a start during a run cannot end or restart it early
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !lastCyc) |=> (busy && !done));

  // R2 / R11: a run only begins from an accepted start
  a_r2_begin: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

endmodule

// File: rtl/sc_mac_dp.sv
module sc_mac_dp
  import sc_mac_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int OP_W       = 8,
  parameter int STREAM_LEN = 256,
  parameter int CNT_W      = 16,
  parameter int SEED       = 20'hACE15
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  macCtrl_t              ctrl,
  input  logic [LANES*OP_W-1:0] actIn,
  input  logic [LANES*OP_W-1:0] wgtIn,
  output logic [CNT_W-1:0]      count
);
  localparam int LANE_BITS = $clog2(LANES);
  localparam int LFSR_W    = LANE_BITS + 2 * OP_W;
  localparam logic [31:0] MASK32 = lfsrMask(LFSR_W);
  localparam logic [LFSR_W-1:0] TAPS = MASK32[LFSR_W-1:0];
  localparam logic [LFSR_W-1:0] SEED_V = (LFSR_W'(SEED) == '0) ? LFSR_W'(1) : LFSR_W'(SEED);
  localparam logic [OP_W-1:0] OFFSET = OP_W'(1) << (OP_W - 1);

  logic [LFSR_W-1:0]    lfsr;
  logic [LANE_BITS-1:0] selLane;
  logic [OP_W-1:0]      sampA;
  logic [OP_W-1:0]      sampW;
  logic [OP_W-1:0]      magA [LANES];
  logic [OP_W-1:0]      magW [LANES];
  logic [LANES-1:0]     laneHit;
  logic                 orBit;

  assign selLane = lfsr[LFSR_W-1 -: LANE_BITS];
  assign sampA   = lfsr[2*OP_W-1:OP_W];
  assign sampW   = lfsr[OP_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr <= SEED_V;
    end else if (ctrl.load) begin
      lfsr <= SEED_V;
    end else if (ctrl.step) begin
      lfsr <= {lfsr[LFSR_W-2:0], ^(lfsr & TAPS)};
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        magA[i] <= '0;
        magW[i] <= '0;
      end else if (ctrl.load) begin
        magA[i] <= actIn[i*OP_W +: OP_W] ^ OFFSET;
        magW[i] <= wgtIn[i*OP_W +: OP_W] ^ OFFSET;
      end
    end
    assign laneHit[i] = (selLane == LANE_BITS'(i)) &&
                        (sampA < magA[i]) && (sampW < magW[i]);
  end

  assign orBit = |laneHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (ctrl.load) begin
      count <= '0;
    end else if (ctrl.step && orBit) begin
      count <= count + 1'b1;
    end
  end

  // R5: lanes never collide at the OR gate
  a_r5_one_lane: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(laneHit));

  // R4: count bounded by the stream length
  a_r4_count_max: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(STREAM_LEN));

  // R4: count advances by at most one per cycle
  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |=> (count == $past(count) || count == $past(count) + 1'b1));

  // R10: count holds while idle without a new start
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.step && !ctrl.load) |=> $stable(count));

  // R8: generator never enters the lock-up state
  a_r8_lfsr_live: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);

endmodule

// File: rtl/sc_or_mac.sv
module sc_or_mac
  import sc_mac_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int STREAM_LEN = 256,
  parameter int SEED       = 20'hACE15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LANES*8-1:0] actIn,
  input  logic [LANES*8-1:0] wgtIn,
  output logic             busy,
  output logic             done,
  output logic [15:0]      count
);
  localparam int OP_W  = 8;
  localparam int CNT_W = 16;

  macCtrl_t ctrl;

  sc_mac_ctrl #(.STREAM_LEN(STREAM_LEN)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctrl (ctrl),
    .busy (busy),
    .done (done)
  );

  sc_mac_dp #(
    .LANES(LANES), .OP_W(OP_W), .STREAM_LEN(STREAM_LEN),
    .CNT_W(CNT_W), .SEED(SEED)
  ) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .ctrl (ctrl),
    .actIn(actIn),
    .wgtIn(wgtIn),
    .count(count)
  );

endmodule

// File: tb/sim_sc_or_mac.sv
module sim_sc_or_mac;
  localparam int LANES = 16;
  localparam int LEN   = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [LANES*8-1:0] actIn = '0;
  logic [LANES*8-1:0] wgtIn = '0;
  logic busy, done;
  logic [15:0] count;

  int testCount = 0;
  int failCount = 0;
  int refZero, refRamp;

  logic signed [7:0] aV [LANES];
  logic signed [7:0] wV [LANES];

  always #4 clk = ~clk;

  sc_or_mac u0 (.clk(clk), .rstN(rstN), .start(start), .actIn(actIn),
                .wgtIn(wgtIn), .busy(busy), .done(done), .count(count));

  task automatic check(input string req, input int act, input int exp, input bit ok);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic packOps();
    for (int i = 0; i < LANES; i++) begin
      actIn[i*8 +: 8] = aV[i];
      wgtIn[i*8 +: 8] = wV[i];
    end
  endtask

  function automatic real expectVal();
    real s = 0.0;
    for (int i = 0; i < LANES; i++)
      s += real'(int'(aV[i]) + 128) * real'(int'(wV[i]) + 128);
    return s / (LANES * 65536.0) * LEN;
  endfunction

  // start at a negedge, then wait for done; returns cycles waited after the start edge
  task automatic runMac(output int waited);
    packOps();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 1;
    while (!done && waited < 400) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic checkTol(input string req);
    int w;
    real e;
    e = expectVal();
    runMac(w);
    check(req, w, LEN + 1, w == LEN + 1);
    check(req, int'(count), int'(e),
          (real'(count) - e <= 24.0) && (e - real'(count) <= 24.0));
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0, busy == 1'b0);
    check("R1 done", int'(done), 0, done == 1'b0);
    check("R1 count", int'(count), 0, count == 16'd0);
  endtask

  task automatic t_zero_mid();
    int w;
    for (int i = 0; i < LANES; i++) begin aV[i] = 0; wV[i] = 0; end
    packOps();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy", int'(busy), 1, busy == 1'b1);
    actIn = '1; wgtIn = '1;   // R2: later input changes have no effect
    w = 1;
    while (!done && w < 400) begin @(negedge clk); w++; end
    check("R3 latency", w, LEN + 1, w == LEN + 1);
    check("R3 busy low", int'(busy), 0, busy == 1'b0);
    check("R2 R7 mid count", int'(count), 64, count >= 40 && count <= 88);
    refZero = count;
    @(negedge clk);
    check("R3 pulse", int'(done), 0, done == 1'b0);
  endtask

  task automatic t_full_scale();
    for (int i = 0; i < LANES; i++) begin aV[i] = 127; wV[i] = 127; end
    checkTol("R7 full scale");
    check("R4 max", int'(count), LEN, count <= 16'(LEN));
  endtask

  task automatic t_min_act();
    int w;
    for (int i = 0; i < LANES; i++) begin aV[i] = -128; wV[i] = 127; end
    runMac(w);
    check("R6 zero magnitude", int'(count), 0, count == 16'd0);
  endtask

  task automatic t_sparse();
    for (int i = 0; i < LANES; i++) begin aV[i] = -128; wV[i] = -128; end
    aV[5] = 127; wV[5] = 127;
    checkTol("R12 sparse");
  endtask

  task automatic t_ramp_repeat();
    int w;
    for (int i = 0; i < LANES; i++) begin aV[i] = 8'(i * 16 - 128); wV[i] = 8'(64 - i * 8); end
    checkTol("R7 ramp");
    refRamp = count;
    runMac(w);
    check("R8 repeat", int'(count), refRamp, int'(count) == refRamp);
  endtask

  task automatic t_busy_start();
    int w;
    for (int i = 0; i < LANES; i++) begin aV[i] = 8'(i * 16 - 128); wV[i] = 8'(64 - i * 8); end
    packOps();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 1;
    repeat (99) begin @(negedge clk); w++; end
    actIn = '0; wgtIn = '0;
    start = 1'b1;               // R9: should be ignored
    @(negedge clk); w++;
    start = 1'b0;
    while (!done && w < 400) begin @(negedge clk); w++; end
    check("R9 timing", w, LEN + 1, w == LEN + 1);
    check("R9 count", int'(count), refRamp, int'(count) == refRamp);
  endtask

  task automatic t_start_on_done();
    int w;
    check("R11 done seen", int'(done), 1, done == 1'b1);
    for (int i = 0; i < LANES; i++) begin aV[i] = 0; wV[i] = 0; end
    packOps();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 accepted", int'(busy), 1, busy == 1'b1);
    w = 1;
    while (!done && w < 400) begin @(negedge clk); w++; end
    check("R11 latency", w, LEN + 1, w == LEN + 1);
    check("R11 count", int'(count), refZero, int'(count) == refZero);
  endtask

  task automatic t_hold();
    logic [15:0] held;
    held = count;
    actIn = '1; wgtIn = '0;
    repeat (20) @(negedge clk);
    check("R10 hold", int'(count), int'(held), count == held);
    check("R10 idle", int'(busy), 0, busy == 1'b0 && done == 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_zero_mid();
    t_full_scale();
    t_min_act();
    t_sparse();
    t_ramp_repeat();
    t_busy_start();
    t_start_on_done();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule